// File: doc/BRIEF.md
# Per-Pin GPIO Trigger Detector

This block watches a port of asynchronous GPIO input levels and raises a sticky pending flag for every pin whose configured trigger condition occurs. Each pin can be set to trigger on a level or on an edge. The level or edge can be high/rising or low/falling. In edge mode a pin can instead trigger on any change. Software reads the pending word and acknowledges flags by writing ones to the bits it has serviced. It can also write back the word it just read.

Two summary outputs come from the pending flags and the live trigger conditions. The interrupt request is the OR of the pending flags that have their interrupt enable set. The wake request is asserted while any wake-enabled pin meets its trigger condition. Each input passes through a two-flop synchronizer.

A small priming state machine runs after reset. Its states are FLUSH_A, FLUSH_B, LOAD and ARMED. The transitions are FLUSH_A→FLUSH_B, FLUSH_B→LOAD and LOAD→ARMED, one per clock, and ARMED→ARMED after that. Detection stays off until ARMED. This lets the synchronizer fill and the previous-sample register load from the real input level, so a static input cannot produce a false edge.

Top module: `gpio_trig_detect`

## Requirements
- R1: While reset is held and right after it, all control, enable and pending registers read 0, and `irq` and `wake` are 0.
- R2: After reset is released, detection is off for three clocks (FLUSH_A, FLUSH_B, LOAD). Pins that hold a static level from reset onward set no pending flag, even when any-change edge mode is written in the first cycle.
- R3: A pin in edge mode (level-select bit 0), with any-change 0 and polarity 1, sets its pending flag on a rising input. The flag becomes readable after the third rising clock edge that follows the input change.
- R4: A pin in edge mode with any-change 0 and polarity 0 sets its pending flag on a falling input, with the same latency as R3.
- R5: A pin in edge mode with any-change 1 sets its pending flag on both rising and falling inputs, whatever its polarity bit holds.
- R6: A pin in level mode (level-select bit 1) sets its pending flag while its synchronized input equals its polarity bit. A flag cleared while that level is still present reads as set again right after the clearing write.
- R7: Writing the pending word (address 5) clears every flag written with 1 and leaves flags written with 0 unchanged. Writing back a value just read from address 5 clears all flags that are no longer being set by an active trigger.
- R8: When a trigger sets a flag in the same cycle that a write clears it, the flag ends up set.
- R9: Pending flags are set whatever the interrupt enable holds. `irq` is 1 exactly when some pin has both its pending flag and its interrupt-enable bit (address 3) set.
- R10: `wake` is 1 while any pin with its wake-enable bit (address 4) set meets its trigger condition, whatever its interrupt enable or pending flag holds. An edge gives a one-cycle pulse, one clock before its pending flag appears. A level holds `wake` high for as long as the level is present.
- R11: The register map holds level-select at 0, polarity at 1, any-change at 2, interrupt-enable at 3, wake-enable at 4 and pending at 5; all read back as written. Address 6 returns the synchronized pin levels and ignores writes. Address 7 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_in | input | NPINS | Asynchronous GPIO input levels |
| reg_addr | input | 3 | Register address for reads and writes |
| reg_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| reg_wdata | input | NPINS | Write data |
| reg_rdata | output | NPINS | Combinational read data for `reg_addr` |
| irq | output | 1 | Combined interrupt request |
| wake | output | 1 | Combined wake request |

## Verification
The clash to check is between a trigger that sets a pending flag and a software write that clears the same flag on the same clock. The bench provokes it in two ways.

In level mode the pin's level is still active when the acknowledging write arrives. In edge mode an input toggle is timed so that its third clock edge coincides with a write of all ones to the pending word.

In both cases the pending word read right after the write must still show the triggering pin, and every other flag must be cleared.

// File: rtl/gpio_trig_pkg.sv
package gpio_trig_pkg;

    typedef enum logic [1:0] {
        ST_FLUSH_A = 2'd0,
        ST_FLUSH_B = 2'd1,
        ST_LOAD    = 2'd2,
        ST_ARMED   = 2'd3
    } prime_state_t;

    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] A_LVL = 3'd0;
    localparam logic [ADDR_W-1:0] A_POL = 3'd1;
    localparam logic [ADDR_W-1:0] A_ANY = 3'd2;
    localparam logic [ADDR_W-1:0] A_IEN = 3'd3;
    localparam logic [ADDR_W-1:0] A_WEN = 3'd4;
    localparam logic [ADDR_W-1:0] A_PND = 3'd5;
    localparam logic [ADDR_W-1:0] A_PIN = 3'd6;

endpackage

// File: rtl/gpio_sync2.sv
module gpio_sync2 #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= async_i;
            sync_q <= meta_q;
        end
    end

    assign sync_o = sync_q;
endmodule

// File: rtl/gpio_trig_cond.sv
module gpio_trig_cond #(
    parameter int NPINS = 32
) (
    input  logic             armed_i,
    input  logic [NPINS-1:0] cur_i,
    input  logic [NPINS-1:0] prev_i,
    input  logic [NPINS-1:0] lvl_sel_i,
    input  logic [NPINS-1:0] pol_i,
    input  logic [NPINS-1:0] any_i,
    output logic [NPINS-1:0] hit_o
);
    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        logic rise, fall, edge_hit, lvl_hit;
        assign rise     = cur_i[i] & ~prev_i[i];
        assign fall     = ~cur_i[i] & prev_i[i];
        assign edge_hit = any_i[i] ? (rise | fall) : (pol_i[i] ? rise : fall);
        assign lvl_hit  = pol_i[i] ? cur_i[i] : ~cur_i[i];
        assign hit_o[i] = armed_i & (lvl_sel_i[i] ? lvl_hit : edge_hit);
    end
endmodule

// File: rtl/gpio_pend_bank.sv
module gpio_pend_bank #(
    parameter int NPINS = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] set_i,
    input  logic [NPINS-1:0] clr_i,
    output logic [NPINS-1:0] pend_o
);
    logic [NPINS-1:0] pend_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= (pend_q & ~clr_i) | set_i;
    end

    assign pend_o = pend_q;

    // R8: a trigger beats a clear aimed at the same bit
    assert_set_beats_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((set_i & clr_i) != '0) |=> ((pend_q & $past(set_i & clr_i)) == $past(set_i & clr_i)));

    // R7: with no trigger, only bits written with 1 fall
    assert_w1c_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i == '0) |=> (pend_q == ($past(pend_q) & ~$past(clr_i))));
endmodule

// File: rtl/gpio_trig_detect.sv
module gpio_trig_detect
    import gpio_trig_pkg::*;
#(
    parameter int NPINS = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NPINS-1:0]  pin_in,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [NPINS-1:0]  reg_wdata,
    output logic [NPINS-1:0]  reg_rdata,
    output logic              irq,
    output logic              wake
);
    prime_state_t state_q, state_d;
    logic armed, load_prev;

    logic [NPINS-1:0] sync_lvl, prev_q, hit, pend, clr;
    logic [NPINS-1:0] lvl_sel_q, pol_q, any_q, ien_q, wen_q;

    gpio_sync2 #(.W(NPINS)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_i(pin_in), .sync_o(sync_lvl)
    );

    // priming state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_FLUSH_A;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            ST_FLUSH_A: state_d = ST_FLUSH_B;
            ST_FLUSH_B: state_d = ST_LOAD;
            ST_LOAD:    state_d = ST_ARMED;
            ST_ARMED:   state_d = ST_ARMED;
        endcase
    end

    // state outputs
    always_comb begin
        armed     = 1'b0;
        load_prev = 1'b1;
        unique case (state_q)
            ST_FLUSH_A, ST_FLUSH_B, ST_LOAD: armed = 1'b0;
            ST_ARMED:                        armed = 1'b1;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         prev_q <= '0;
        else if (load_prev) prev_q <= sync_lvl;
    end

    // control registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lvl_sel_q <= '0;
            pol_q     <= '0;
            any_q     <= '0;
            ien_q     <= '0;
            wen_q     <= '0;
        end else if (reg_wr) begin
            unique case (reg_addr)
                A_LVL:   lvl_sel_q <= reg_wdata;
                A_POL:   pol_q     <= reg_wdata;
                A_ANY:   any_q     <= reg_wdata;
                A_IEN:   ien_q     <= reg_wdata;
                A_WEN:   wen_q     <= reg_wdata;
                default: ;
            endcase
        end
    end

    assign clr = (reg_wr && reg_addr == A_PND) ? reg_wdata : '0;

    gpio_trig_cond #(.NPINS(NPINS)) u_cond (
        .armed_i(armed), .cur_i(sync_lvl), .prev_i(prev_q),
        .lvl_sel_i(lvl_sel_q), .pol_i(pol_q), .any_i(any_q), .hit_o(hit)
    );

    gpio_pend_bank #(.NPINS(NPINS)) u_pend (
        .clk(clk), .rst_n(rst_n), .set_i(hit), .clr_i(clr), .pend_o(pend)
    );

    always_comb begin
        unique case (reg_addr)
            A_LVL:   reg_rdata = lvl_sel_q;
            A_POL:   reg_rdata = pol_q;
            A_ANY:   reg_rdata = any_q;
            A_IEN:   reg_rdata = ien_q;
            A_WEN:   reg_rdata = wen_q;
            A_PND:   reg_rdata = pend;
            A_PIN:   reg_rdata = sync_lvl;
            default: reg_rdata = '0;
        endcase
    end

    assign irq  = |(pend & ien_q);
    assign wake = |(hit & wen_q);

    // R2: no new pending bit may appear before the machine is armed
    assert_quiet_until_armed_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_ARMED) |=> ((pend & ~$past(pend)) == '0));

    // R2: once armed, stays armed until reset
    assert_armed_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ARMED) |=> (state_q == ST_ARMED));

    // R9: an interrupt needs a pending flag behind it
    assert_irq_has_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (pend != '0));

    // R10: wake only after priming
    assert_wake_needs_armed_R10: assert property (@(posedge clk) disable iff (!rst_n)
        wake |-> (state_q == ST_ARMED));
endmodule

// File: tb/gpio_trig_detect_test.sv
`timescale 1ns/100ps
module gpio_trig_detect_test;
    import gpio_trig_pkg::*;

    localparam int NPINS = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NPINS-1:0]  pin_in = '0;
    logic [ADDR_W-1:0] reg_addr = '0;
    logic              reg_wr = 1'b0;
    logic [NPINS-1:0]  reg_wdata = '0;
    logic [NPINS-1:0]  reg_rdata;
    logic              irq, wake;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    gpio_trig_detect #(.NPINS(NPINS)) uut (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .reg_addr(reg_addr),
        .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq(irq), .wake(wake)
    );

    task automatic check(input string tag, input logic [NPINS-1:0] act, input logic [NPINS-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [NPINS-1:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a, output logic [NPINS-1:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(5.0 * 150000);
        n_bad++;
        n_chk++;
        $display("FAIL watchdog act=running exp=finished");
        finish_run();
    end

    initial begin
        logic [NPINS-1:0] v, lv, pl, ch, a, exp, act_lvl;
        int p, q;

        // R1: reset state
        pin_in = 32'hFFFF_0F0F;
        repeat (3) @(negedge clk);
        for (int r = 0; r < 6; r++) begin
            rd(r[ADDR_W-1:0], v);
            check($sformatf("R1 reg%0d in reset", r), v, '0);
        end
        check("R1 irq/wake in reset", {30'd0, irq, wake}, '0);

        // R2: release reset, any-change written at once; static pins must not trigger
        @(negedge clk);
        rst_n = 1'b1;
        reg_addr = A_ANY; reg_wdata = '1; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
        repeat (5) @(negedge clk);
        rd(A_PND, v);
        check("R2 no false edge after reset", v, '0);
        check("R1 irq/wake idle after reset", {30'd0, irq, wake}, '0);

        // near-exhaustive sweep: pin i config from bits of k
        for (int rnd = 0; rnd < 2; rnd++) begin
            for (int i = 0; i < NPINS; i++) begin
                logic [4:0] k;
                k = i[4:0] ^ (rnd == 1 ? 5'h1F : 5'h00);
                lv[i] = k[0]; pl[i] = k[1]; ch[i] = k[2]; a[i] = k[3];
            end
            pin_in = a;
            repeat (4) @(negedge clk);
            wr(A_LVL, lv); wr(A_POL, pl); wr(A_ANY, ch);
            wr(A_IEN, '0); wr(A_WEN, '0);
            repeat (4) @(negedge clk);
            if (rnd == 0) begin
                rd(A_LVL, v); check("R11 readback level-select", v, lv);
                rd(A_POL, v); check("R11 readback polarity", v, pl);
                rd(A_ANY, v); check("R11 readback any-change", v, ch);
            end
            // clear all: active level pins come back at once (R6, R8)
            wr(A_PND, '1);
            exp = lv & ~(a ^ pl);
            rd(A_PND, v);
            check("R6 level re-set after clear", v, exp);

            // toggle every pin
            @(negedge clk);
            pin_in = ~a;
            repeat (3) @(posedge clk);
            act_lvl = lv & ~(pl ^ ~a);
            exp = exp | act_lvl | (~lv & (ch | ~(pl ^ ~a)));
            rd(A_PND, v);
            check("R3 rising edge pins", v & ~lv & ~ch & pl, exp & ~lv & ~ch & pl);
            check("R4 falling edge pins", v & ~lv & ~ch & ~pl, exp & ~lv & ~ch & ~pl);
            check("R5 any-change pins", v & ~lv & ch, exp & ~lv & ch);
            check("R6 level pins", v & lv, exp & lv);

            // R9: irq gating by enable
            p = -1; q = -1;
            for (int i = NPINS - 1; i >= 0; i--) begin
                if (exp[i]) p = i; else q = i;
            end
            if (q >= 0) begin
                wr(A_IEN, 32'd1 << q);
                check("R9 irq off for idle pin", {31'd0, irq}, 32'd0);
            end
            if (p >= 0) begin
                wr(A_IEN, 32'd1 << p);
                check("R9 irq on for pending pin", {31'd0, irq}, 32'd1);
            end
            wr(A_IEN, '0);

            // R7: partial clear, then write-back of read word
            wr(A_PND, exp & 32'h0000_FFFF);
            exp = (exp & ~(exp & 32'h0000_FFFF)) | act_lvl;
            rd(A_PND, v);
            check("R7 partial clear", v, exp);
            rd(A_PND, v);
            wr(A_PND, v);
            rd(A_PND, v);
            check("R7 write-back clears serviced", v, act_lvl);
        end

        // R8: edge set lands in the same cycle as a clear-all
        pin_in = '0;
        wr(A_LVL, '0); wr(A_POL, '1); wr(A_ANY, '0);
        repeat (4) @(negedge clk);
        wr(A_PND, '1);
        rd(A_PND, v);
        check("R7 clear-all idle", v, '0);
        @(negedge clk);
        pin_in = 32'h0000_0020;
        repeat (2) @(posedge clk);
        wr(A_PND, '1);
        rd(A_PND, v);
        check("R8 edge set beats clear", v, 32'h0000_0020);

        // R10: wake pulse from an edge, no irq enable
        wr(A_PND, '1);
        wr(A_WEN, 32'h0000_0001);
        @(negedge clk);
        pin_in = 32'h0000_0021;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R10 wake pulse on edge", {31'd0, wake}, 32'd1);
        @(negedge clk);
        check("R10 wake pulse ends", {31'd0, wake}, 32'd0);

        // R10: steady wake from a level pin
        wr(A_LVL, 32'h0000_0002);
        wr(A_WEN, 32'h0000_0002);
        @(negedge clk);
        pin_in = 32'h0000_0023;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R10 level wake", {31'd0, wake}, 32'd1);
        wr(A_PND, '1);
        check("R10 level wake holds after clear", {31'd0, wake}, 32'd1);
        check("R9 irq stays off with no enable", {31'd0, irq}, 32'd0);

        // R11: pin register read-only, reserved reads zero
        wr(A_PIN, 32'hDEAD_BEEF);
        rd(A_PIN, v);
        check("R11 pin register ignores writes", v, 32'h0000_0023);
        rd(3'd7, v);
        check("R11 reserved address", v, '0);

        finish_run();
    end
endmodule